// File: doc/BRIEF.md
# Audio Sample Unpacker and Formatter

This block sits between a memory read engine and a multi-lane serial audio transmitter. It accepts 32-bit words fetched from consecutive, increasing memory addresses, splits them into samples, puts each sample into an output slot, and hands over one complete set of output samples per audio frame. A slot is defined by a serial lane and a channel (left or right). Memory samples can be 16 or 32 bits wide. The lanes can carry stereo or mono data. One, two, three or four lanes can be active. The byte order used to assemble each sample is selectable. An optional conversion turns unsigned offset-binary data into two's complement by flipping the top bit.

Words arrive on a valid/ready handshake. A frame strobe from the transmitter side marks each frame boundary.

- **Complete frame:** if every active slot holds a fresh sample when the strobe arrives, the whole set is released to the outputs.
- **Incomplete frame:** if any active slot is still empty, the previous set is repeated and an underrun pulse is raised. Partial progress is kept for the next frame.

Slots that are not fed from memory send a zero, and that zero also passes through the sign conversion.

Top module: `audio_sample_unpacker`

## Requirements
- R1: After reset, `samples_o` is all zero, `frame_valid_o` and `underrun_o` are low, and `word_ready_o` is high when the format code is valid.
- R2: Format code 00 selects 16-bit memory samples, two per word. The sample at the lower address comes first. Byte k of the word is at bits [8k+7:8k] and sits at address offset k. When `little_end_i`=1, the byte at the higher address is the more significant byte; when it is 0, the byte at the lower address is.
- R3: Format code 01 selects 32-bit memory samples, one per word. The output sample is the upper 16 bits of the 32-bit value, assembled with the same byte-order rule as R2.
- R4: In stereo mode, successive samples fill lane 0 left, lane 0 right, lane 1 left, lane 1 right, and so on, up to the last active lane. Output position p = 2*lane + channel (left=0, right=1) appears on `samples_o[16p+15:16p]`.
- R5: In mono mode, successive samples fill lane 0 left, lane 1 left, and so on. No right channel takes a sample from memory.
- R6: `lane_sel_i` values 0, 1, 2 and 3 activate 1, 2, 3 and 4 lanes. Every slot not fed from memory outputs zero.
- R7: When `sign_conv_i`=1, bit 15 of every output sample is inverted. This includes the zero in unfed slots, which then reads 16'h8000.
- R8: A `frame_tick_i` pulse that finds all active slots filled updates `samples_o` and raises `frame_valid_o` for one cycle, one clock after the strobe.
- R9: A `frame_tick_i` pulse that finds an active slot unfilled raises `underrun_o` for one cycle, one clock after the strobe, and leaves `samples_o` unchanged. Samples already collected are kept for the next frame.
- R10: Format codes 10 and 11 (8-bit companded data) are invalid. `mode_err_o` is high, `word_ready_o` is low, and no word is consumed.
- R11: When a 16-bit word holds a second sample that does not fit in the current frame, that sample fills the first slot of the next frame.
- R12: `word_ready_o` is low while `frame_tick_i` is high and while every active slot is already filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_fmt_i | input | 2 | Memory format code: 00 = 16-bit, 01 = 32-bit, 10/11 = invalid |
| stereo_i | input | 1 | 1 = stereo fill, 0 = mono fill |
| lane_sel_i | input | 2 | Number of active lanes minus one |
| little_end_i | input | 1 | Byte order used to assemble samples |
| sign_conv_i | input | 1 | Invert the sample MSB |
| word_i | input | 32 | Memory word |
| word_valid_i | input | 1 | `word_i` is valid |
| word_ready_o | output | 1 | Block accepts `word_i` this cycle |
| frame_tick_i | input | 1 | Frame boundary strobe |
| samples_o | output | 128 | Eight 16-bit output slots, position p = 2*lane + channel |
| frame_valid_o | output | 1 | New sample set released |
| underrun_o | output | 1 | Frame strobe found the set incomplete |
| mode_err_o | output | 1 | Invalid format code selected |

## Verification
The assertions check the following properties on every cycle:
- The handshake is closed during a strobe and under an invalid format.
- Release and underrun pulses follow only a strobe and are mutually exclusive.
- The output set never changes except on a release, which covers the repeat-on-underrun rule.

Only the bench's scenarios can show the following:
- Which byte goes where, the fill order across lanes and channels, the zero fill with and without sign conversion, and the carry of a leftover half-word into the next frame.
- That partially collected samples survive an underrun.

// File: rtl/audio_unpack_pkg.sv
package audio_unpack_pkg;
   typedef enum logic [1:0] {
      FMT_LIN16 = 2'b00,
      FMT_LIN32 = 2'b01,
      FMT_CMP_A = 2'b10,
      FMT_CMP_B = 2'b11
   } mem_fmt_e;
endpackage

// File: rtl/aup_mode_decode.sv
module aup_mode_decode
   import audio_unpack_pkg::*;
#(
   parameter int MAX_LANES = 4,
   localparam int LSW = $clog2(MAX_LANES),
   localparam int LAW = LSW + 1,
   localparam int CW  = $clog2(2 * MAX_LANES + 1)
) (
   input  logic [1:0]     mem_fmt_i,
   input  logic           stereo_i,
   input  logic [LSW-1:0] lane_sel_i,
   output logic           mode_ok_o,
   output logic           wide_o,
   output logic [LAW-1:0] lanes_act_o,
   output logic [CW-1:0]  need_o
);
   mem_fmt_e fmt;

   always_comb begin
      fmt         = mem_fmt_e'(mem_fmt_i);
      mode_ok_o   = (fmt == FMT_LIN16) || (fmt == FMT_LIN32);
      wide_o      = (fmt == FMT_LIN32);
      lanes_act_o = LAW'(lane_sel_i) + LAW'(1);
      need_o      = stereo_i ? CW'({lanes_act_o, 1'b0}) : CW'(lanes_act_o);
   end
endmodule

// File: rtl/aup_word_split.sv
module aup_word_split #(
   parameter int SAMPLE_W = 16,
   localparam int WORD_W = 2 * SAMPLE_W,
   localparam int NB     = SAMPLE_W / 8
) (
   input  logic [WORD_W-1:0]   word_i,
   input  logic                wide_i,
   input  logic                little_i,
   output logic [SAMPLE_W-1:0] samp0_o,
   output logic [SAMPLE_W-1:0] samp1_o,
   output logic                two_o
);
   logic [SAMPLE_W-1:0] lo_sw, hi_sw, lo, hi;

   for (genvar b = 0; b < NB; b++) begin : g_swap
      assign lo_sw[b*8 +: 8] = word_i[(NB-1-b)*8 +: 8];
      assign hi_sw[b*8 +: 8] = word_i[SAMPLE_W + (NB-1-b)*8 +: 8];
   end

   always_comb begin
      lo      = little_i ? word_i[SAMPLE_W-1:0] : lo_sw;
      hi      = little_i ? word_i[WORD_W-1:SAMPLE_W] : hi_sw;
      two_o   = !wide_i;
      samp0_o = wide_i ? (little_i ? hi : lo) : lo;
      samp1_o = hi;
   end
endmodule

// File: rtl/aup_slot_fill.sv
module aup_slot_fill #(
   parameter int SLOTS    = 8,
   parameter int SAMPLE_W = 16,
   localparam int CW = $clog2(SLOTS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mode_ok_i,
   input  logic [CW-1:0]             need_i,
   input  logic                      word_valid_i,
   input  logic [SAMPLE_W-1:0]       samp0_i,
   input  logic [SAMPLE_W-1:0]       samp1_i,
   input  logic                      two_i,
   input  logic                      tick_i,
   output logic                      ready_o,
   output logic                      release_o,
   output logic [SLOTS*SAMPLE_W-1:0] slot_img_o
);
   logic [CW-1:0]       fill_q;
   logic                spare_v_q;
   logic [SAMPLE_W-1:0] spare_q;
   logic                room, full, take, move, fits;

   always_comb begin
      room      = fill_q < need_i;
      full      = fill_q == need_i;
      fits      = (fill_q + CW'(1)) < need_i;
      ready_o   = mode_ok_i && !tick_i && !spare_v_q && room;
      take      = word_valid_i && ready_o;
      move      = mode_ok_i && !tick_i && spare_v_q && room;
      release_o = tick_i && full && mode_ok_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q    <= '0;
         spare_v_q <= 1'b0;
         spare_q   <= '0;
      end else if (release_o) begin
         fill_q <= '0;
      end else if (move) begin
         fill_q    <= fill_q + CW'(1);
         spare_v_q <= 1'b0;
      end else if (take) begin
         if (two_i && fits) begin
            fill_q <= fill_q + CW'(2);
         end else begin
            fill_q <= fill_q + CW'(1);
            if (two_i) begin
               spare_q   <= samp1_i;
               spare_v_q <= 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [SAMPLE_W-1:0] val_q;
      logic                at0, at1;
      assign at0 = fill_q == CW'(i);
      assign at1 = (fill_q + CW'(1)) == CW'(i);
      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= '0;
         else if (!release_o) begin
            if (move && at0)
               val_q <= spare_q;
            else if (!move && take && at0)
               val_q <= samp0_i;
            else if (!move && take && two_i && fits && at1)
               val_q <= samp1_i;
         end
      end
      assign slot_img_o[i*SAMPLE_W +: SAMPLE_W] = val_q;
   end
endmodule

// File: rtl/aup_frame_out.sv
module aup_frame_out #(
   parameter int MAX_LANES = 4,
   parameter int SAMPLE_W  = 16,
   localparam int SLOTS = 2 * MAX_LANES,
   localparam int LAW   = $clog2(MAX_LANES) + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_i,
   input  logic                      release_i,
   input  logic                      stereo_i,
   input  logic                      sign_conv_i,
   input  logic [LAW-1:0]            lanes_act_i,
   input  logic [SLOTS*SAMPLE_W-1:0] slot_img_i,
   output logic [SLOTS*SAMPLE_W-1:0] samples_o,
   output logic                      frame_valid_o,
   output logic                      underrun_o
);
   for (genvar p = 0; p < SLOTS; p++) begin : g_pos
      localparam int LANE = p / 2;
      localparam int CHAN = p % 2;
      logic [SAMPLE_W-1:0] src, val, held_q;
      logic                fed;

      always_comb begin
         src = stereo_i ? slot_img_i[p*SAMPLE_W +: SAMPLE_W]
                        : slot_img_i[LANE*SAMPLE_W +: SAMPLE_W];
         fed = (lanes_act_i > LAW'(LANE)) && (stereo_i || (CHAN == 0));
         val = fed ? src : '0;
         val[SAMPLE_W-1] = val[SAMPLE_W-1] ^ sign_conv_i;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)         held_q <= '0;
         else if (release_i) held_q <= val;
      end
      assign samples_o[p*SAMPLE_W +: SAMPLE_W] = held_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_valid_o <= 1'b0;
         underrun_o    <= 1'b0;
      end else begin
         frame_valid_o <= release_i;
         underrun_o    <= tick_i && !release_i;
      end
   end
endmodule

// File: rtl/audio_sample_unpacker.sv
module audio_sample_unpacker #(
   parameter int MAX_LANES = 4,
   parameter int SAMPLE_W  = 16,
   localparam int WORD_W = 2 * SAMPLE_W,
   localparam int SLOTS  = 2 * MAX_LANES,
   localparam int LSW    = $clog2(MAX_LANES),
   localparam int LAW    = LSW + 1,
   localparam int CW     = $clog2(SLOTS + 1),
   localparam int OUT_W  = SLOTS * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mem_fmt_i,
   input  logic              stereo_i,
   input  logic [LSW-1:0]    lane_sel_i,
   input  logic              little_end_i,
   input  logic              sign_conv_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              word_valid_i,
   output logic              word_ready_o,
   input  logic              frame_tick_i,
   output logic [OUT_W-1:0]  samples_o,
   output logic              frame_valid_o,
   output logic              underrun_o,
   output logic              mode_err_o
);
   if (SAMPLE_W % 8 != 0 || SAMPLE_W < 8) begin : g_bad_width
      $error("SAMPLE_W must be a nonzero multiple of 8");
   end
   if (MAX_LANES < 2 || (1 << LSW) != MAX_LANES) begin : g_bad_lanes
      $error("MAX_LANES must be a power of two, at least 2");
   end

   logic                mode_ok, wide, two, rel;
   logic [LAW-1:0]      lanes_act;
   logic [CW-1:0]       need;
   logic [SAMPLE_W-1:0] s0, s1;
   logic [OUT_W-1:0]    slot_img;

   aup_mode_decode #(.MAX_LANES(MAX_LANES)) u_dec (
      .mem_fmt_i  (mem_fmt_i),
      .stereo_i   (stereo_i),
      .lane_sel_i (lane_sel_i),
      .mode_ok_o  (mode_ok),
      .wide_o     (wide),
      .lanes_act_o(lanes_act),
      .need_o     (need)
   );

   aup_word_split #(.SAMPLE_W(SAMPLE_W)) u_split (
      .word_i  (word_i),
      .wide_i  (wide),
      .little_i(little_end_i),
      .samp0_o (s0),
      .samp1_o (s1),
      .two_o   (two)
   );

   aup_slot_fill #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_ok_i   (mode_ok),
      .need_i      (need),
      .word_valid_i(word_valid_i),
      .samp0_i     (s0),
      .samp1_i     (s1),
      .two_i       (two),
      .tick_i      (frame_tick_i),
      .ready_o     (word_ready_o),
      .release_o   (rel),
      .slot_img_o  (slot_img)
   );

   aup_frame_out #(.MAX_LANES(MAX_LANES), .SAMPLE_W(SAMPLE_W)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (frame_tick_i),
      .release_i    (rel),
      .stereo_i     (stereo_i),
      .sign_conv_i  (sign_conv_i),
      .lanes_act_i  (lanes_act),
      .slot_img_i   (slot_img),
      .samples_o    (samples_o),
      .frame_valid_o(frame_valid_o),
      .underrun_o   (underrun_o)
   );

   assign mode_err_o = !mode_ok;
endmodule

// File: rtl/audio_sample_unpacker_chk.sv
module audio_sample_unpacker_chk #(
   parameter int MAX_LANES = 4,
   parameter int SAMPLE_W  = 16,
   localparam int OUT_W = 2 * MAX_LANES * SAMPLE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_tick_i,
   input logic             word_ready_o,
   input logic             mode_err_o,
   input logic             frame_valid_o,
   input logic             underrun_o,
   input logic [OUT_W-1:0] samples_o
);
   assert_no_accept_bad_fmt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err_o |-> !word_ready_o);

   assert_closed_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick_i |-> !word_ready_o);

   assert_release_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |-> $past(frame_tick_i));

   assert_underrun_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |-> $past(frame_tick_i));

   assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frame_valid_o, underrun_o}));

   assert_hold_without_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid_o |-> $stable(samples_o));
endmodule

bind audio_sample_unpacker audio_sample_unpacker_chk #(
   .MAX_LANES(MAX_LANES), .SAMPLE_W(SAMPLE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_tick_i (frame_tick_i),
   .word_ready_o (word_ready_o),
   .mode_err_o   (mode_err_o),
   .frame_valid_o(frame_valid_o),
   .underrun_o   (underrun_o),
   .samples_o    (samples_o)
);

// File: tb/sim_audio_sample_unpacker.sv
module sim_audio_sample_unpacker;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mem_fmt_i = 2'b00;
   logic         stereo_i = 1'b1;
   logic [1:0]   lane_sel_i = 2'd0;
   logic         little_end_i = 1'b1;
   logic         sign_conv_i = 1'b0;
   logic [31:0]  word_i = '0;
   logic         word_valid_i = 1'b0;
   logic         word_ready_o;
   logic         frame_tick_i = 1'b0;
   logic [127:0] samples_o;
   logic         frame_valid_o, underrun_o, mode_err_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   audio_sample_unpacker u0 (
      .clk(clk), .rst_n(rst_n), .mem_fmt_i(mem_fmt_i), .stereo_i(stereo_i),
      .lane_sel_i(lane_sel_i), .little_end_i(little_end_i), .sign_conv_i(sign_conv_i),
      .word_i(word_i), .word_valid_i(word_valid_i), .word_ready_o(word_ready_o),
      .frame_tick_i(frame_tick_i), .samples_o(samples_o), .frame_valid_o(frame_valid_o),
      .underrun_o(underrun_o), .mode_err_o(mode_err_o)
   );

   typedef struct packed {
      logic [1:0]   fmt;
      logic         st;
      logic [1:0]   lanes;
      logic         le;
      logic         sc;
      logic [2:0]   nw;
      logic [127:0] words;
      logic [127:0] expv;
   } vec_t;

   // words: word 0 in bits [31:0]; expv: position p in bits [16p+15:16p]
   localparam vec_t VECS [0:6] = '{
      '{2'b00, 1'b1, 2'd0, 1'b1, 1'b0, 3'd1, 128'hA1B2C3D4,
        128'h0000_0000_0000_0000_0000_0000_A1B2_C3D4},
      '{2'b00, 1'b1, 2'd0, 1'b0, 1'b0, 3'd1, 128'hA1B2C3D4,
        128'h0000_0000_0000_0000_0000_0000_B2A1_D4C3},
      '{2'b01, 1'b1, 2'd1, 1'b1, 1'b0, 3'd4, 128'h77665544_0F0E0D0C_9ABCDEF0_12345678,
        128'h0000_0000_0000_0000_7766_0F0E_9ABC_1234},
      '{2'b01, 1'b0, 2'd3, 1'b0, 1'b0, 3'd4, 128'h77665544_0F0E0D0C_9ABCDEF0_12345678,
        128'h0000_4455_0000_0C0D_0000_F0DE_0000_7856},
      '{2'b00, 1'b0, 2'd1, 1'b1, 1'b1, 3'd1, 128'h00018000,
        128'h8000_8000_8000_8000_8000_8001_8000_0000},
      '{2'b00, 1'b1, 2'd3, 1'b0, 1'b0, 3'd4, 128'h08000700_06000500_04000300_02000100,
        128'h0008_0007_0006_0005_0004_0003_0002_0001},
      '{2'b00, 1'b1, 2'd2, 1'b1, 1'b1, 3'd3, 128'h00060005_00040003_00020001,
        128'h8000_8000_8006_8005_8004_8003_8002_8001}
   };

   function automatic string vec_tags(input int i);
      case (i)
         0: return "R2 R4 little-endian 16-bit stereo";
         1: return "R2 big-endian 16-bit stereo";
         2: return "R3 R4 32-bit little-endian two lanes";
         3: return "R3 R5 R6 32-bit big-endian mono four lanes";
         4: return "R5 R6 R7 mono sign conversion and zero fill";
         5: return "R4 R6 stereo four lanes big-endian";
         default: return "R6 R7 R8 stereo three lanes sign conversion";
      endcase
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      word_valid_i = 1'b0;
      frame_tick_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push(input logic [31:0] w);
      word_i = w;
      word_valid_i = 1'b1;
      #1;
      while (!word_ready_o) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      word_valid_i = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      frame_tick_i = 1'b1;
      @(negedge clk);
      frame_tick_i = 1'b0;
      #1;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      #1;
      check("R1 samples", samples_o, '0);
      check("R1 pulses", {126'd0, frame_valid_o, underrun_o}, '0);
      check("R1 ready", {127'd0, word_ready_o}, 128'd1);

      // table of vectors: R2 to R8 by mode
      for (int i = 0; i < 7; i++) begin
         mem_fmt_i    = VECS[i].fmt;
         stereo_i     = VECS[i].st;
         lane_sel_i   = VECS[i].lanes;
         little_end_i = VECS[i].le;
         sign_conv_i  = VECS[i].sc;
         do_reset();
         for (int w = 0; w < int'(VECS[i].nw); w++) push(VECS[i].words[w*32 +: 32]);
         tick();
         check({vec_tags(i), " valid (R8)"}, {127'd0, frame_valid_o}, 128'd1);
         check(vec_tags(i), samples_o, VECS[i].expv);
      end

      // R9: underrun repeats previous set, keeps partial progress
      mem_fmt_i = 2'b00; stereo_i = 1'b1; lane_sel_i = 2'd1;
      little_end_i = 1'b1; sign_conv_i = 1'b0;
      do_reset();
      push(32'h0002_0001);
      push(32'h0004_0003);
      tick();
      check("R8 first frame", samples_o, 128'h0004_0003_0002_0001);
      push(32'h0006_0005);
      tick();
      check("R9 underrun pulse", {126'd0, frame_valid_o, underrun_o}, 128'd1);
      check("R9 samples repeated", samples_o, 128'h0004_0003_0002_0001);
      push(32'h0008_0007);
      tick();
      check("R9 progress kept", samples_o, 128'h0008_0007_0006_0005);

      // R11 and R12: leftover half-word carries, ready low when full
      mem_fmt_i = 2'b00; stereo_i = 1'b0; lane_sel_i = 2'd0;
      do_reset();
      push(32'h0002_0001);
      #1;
      check("R12 ready low when full", {127'd0, word_ready_o}, 128'd0);
      tick();
      check("R11 first sample", samples_o[15:0], 128'h0001);
      tick();
      check("R11 carried sample valid", {127'd0, frame_valid_o}, 128'd1);
      check("R11 carried sample", samples_o[15:0], 128'h0002);

      // R12: ready closed during strobe with room left
      do_reset();
      @(negedge clk);
      frame_tick_i = 1'b1;
      #1;
      check("R12 ready low on tick", {127'd0, word_ready_o}, 128'd0);
      @(negedge clk);
      frame_tick_i = 1'b0;

      // R10: invalid format consumes nothing
      mem_fmt_i = 2'b10; stereo_i = 1'b1; lane_sel_i = 2'd0;
      do_reset();
      word_i = 32'h1234_5678;
      word_valid_i = 1'b1;
      #1;
      check("R10 mode error", {127'd0, mode_err_o}, 128'd1);
      check("R10 ready low", {127'd0, word_ready_o}, 128'd0);
      repeat (3) @(negedge clk);
      word_valid_i = 1'b0;
      mem_fmt_i = 2'b00;
      tick();
      check("R10 nothing consumed", {126'd0, frame_valid_o, underrun_o}, 128'd1);
      check("R10 samples untouched", samples_o, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule